// File: doc/BRIEF.md
# Dual-Stack Exclusive-Or Stack Execution Unit

This block is the execution core of a minimal stack machine. It keeps a data stack and a separate return stack. It executes one primitive per clock: duplicate the top, discard the top, copy the second item over the top, move the top to the return stack, move the return top back, or combine the top two items with a bitwise exclusive-or. A separate literal port pushes a new value as the top. The top two data items live in registers and drive the `tos` and `nos` outputs directly. Deeper data items spill into a circular array, and the return stack is its own circular array.

The core has no native exchange primitive. Software exchanges the top two items with the six-step sequence OVER, PUSH, OVER, XOR, XOR, POP. That sequence borrows one return-stack slot and gives it back. Both stacks wrap silently at their depth, as circular hardware stacks do, and no error is flagged.

Top module: `dual_stack_core`

## Requirements
- R1: While `rst` is high at a clock edge, `tos` and `nos` become 0 and both stack pointers return to their start position.
- R2: DUP (`op_code` 1) leaves `tos` unchanged, copies it into `nos`, and spills the old `nos` one level deeper.
- R3: DROP (`op_code` 2) moves `nos` into `tos` and refills `nos` from the most recently spilled data item.
- R4: OVER (`op_code` 3) puts the old `nos` in `tos` and the old `tos` in `nos`, and spills the old `nos`, so the stack grows by one.
- R5: PUSH (`op_code` 4) moves `tos` onto the return stack and shrinks the data stack by one. POP (`op_code` 5) moves the return-stack top into `tos` and grows the data stack by one. Values come back in last-in-first-out order.
- R6: XOR (`op_code` 6) replaces the top two items with the single item `tos ^ nos` and refills `nos` from the spill area.
- R7: `lit_valid` pushes `lit_data` as the new `tos` (old `tos` to `nos`). When `lit_valid` and `op_valid` are both high in the same cycle, only the literal executes.
- R8: Exactly one primitive executes per clock edge at which `op_valid` is high. With `op_valid` low, or with `op_code` 0 (idle) or 7 (reserved), `tos`, `nos` and both stacks keep their contents.
- R9: The data stack holds DS_DEPTH+2 items (10 by default). Spilling past that overwrites the oldest spill slot without notice. After eleven literals v1..v11 and nine DROPs, `tos` is v2. One more DROP gives v9.
- R10: The return stack holds RS_DEPTH items (8 by default) and wraps the same way. After nine PUSHes of r1..r9, eight POPs return r9 down to r2, and a ninth POP returns r9.
- R11: The sequence OVER, PUSH, OVER, XOR, XOR, POP exchanges `tos` and `nos` and leaves the return stack as it was. A value pushed onto the return stack beforehand is the next one a POP returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Execute `op_code` this cycle |
| op_code | input | 3 | Primitive: 0 idle, 1 DUP, 2 DROP, 3 OVER, 4 PUSH, 5 POP, 6 XOR, 7 reserved |
| lit_valid | input | 1 | Push `lit_data` this cycle; wins over `op_valid` |
| lit_data | input | WIDTH | Literal value |
| tos | output | WIDTH | Registered top of data stack |
| nos | output | WIDTH | Registered second data item |

## Verification
On every cycle, the assertions check how `tos` and `nos` relate to the previous cycle: DUP, DROP, OVER, XOR and literal pushes, the priority of the literal, the hold when idle, and the reset values. Several effects only show up later through the ports, so only the bench scenarios can reveal them. These are the refill of `nos` from the spill array, the round trip through the return stack, silent wrap-around on both stacks, and the return stack being left balanced after the exchange sequence. A behavioural queue model follows every random and exchange cycle, and directed runs cover the two wrap cases.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_DUP  = 3'd1,
    OP_DROP = 3'd2,
    OP_OVER = 3'd3,
    OP_PUSH = 3'd4,
    OP_POP  = 3'd5,
    OP_XOR  = 3'd6,
    OP_RSV  = 3'd7
  } op_e;

  // source of the next top-of-stack value
  typedef enum logic [2:0] {
    TS_KEEP,
    TS_NOS,
    TS_LIT,
    TS_RET,
    TS_XOR
  } tsel_e;

  // source of the next second-item value
  typedef enum logic [1:0] {
    NS_KEEP,
    NS_TOS,
    NS_SPILL
  } nsel_e;

  typedef struct packed {
    logic  ds_push;
    logic  ds_pop;
    logic  rs_push;
    logic  rs_pop;
    tsel_e tsel;
    nsel_e nsel;
  } ctrl_t;

endpackage

// File: rtl/dsc_decode.sv
module dsc_decode
  import dsc_pkg::*;
(
  input  logic       op_valid,
  input  logic [2:0] op_code,
  input  logic       lit_valid,
  output ctrl_t      ctrl
);

  op_e op;
  assign op = op_e'(op_code);

  always_comb begin
    ctrl = '{ds_push: 1'b0, ds_pop: 1'b0, rs_push: 1'b0, rs_pop: 1'b0,
             tsel: TS_KEEP, nsel: NS_KEEP};
    if (lit_valid) begin
      ctrl.ds_push = 1'b1;
      ctrl.tsel    = TS_LIT;
      ctrl.nsel    = NS_TOS;
    end else if (op_valid) begin
      unique case (op)
        OP_DUP: begin
          ctrl.ds_push = 1'b1;
          ctrl.nsel    = NS_TOS;
        end
        OP_DROP: begin
          ctrl.ds_pop = 1'b1;
          ctrl.tsel   = TS_NOS;
          ctrl.nsel   = NS_SPILL;
        end
        OP_OVER: begin
          ctrl.ds_push = 1'b1;
          ctrl.tsel    = TS_NOS;
          ctrl.nsel    = NS_TOS;
        end
        OP_PUSH: begin
          ctrl.ds_pop  = 1'b1;
          ctrl.rs_push = 1'b1;
          ctrl.tsel    = TS_NOS;
          ctrl.nsel    = NS_SPILL;
        end
        OP_POP: begin
          ctrl.ds_push = 1'b1;
          ctrl.rs_pop  = 1'b1;
          ctrl.tsel    = TS_RET;
          ctrl.nsel    = NS_TOS;
        end
        OP_XOR: begin
          ctrl.ds_pop = 1'b1;
          ctrl.tsel   = TS_XOR;
          ctrl.nsel   = NS_SPILL;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dsc_lifo_ring.sv
module dsc_lifo_ring #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    ptr;
  logic [AW-1:0]    ptr_up;
  logic [AW-1:0]    ptr_dn;

  assign ptr_up = ptr + AW'(1);
  assign ptr_dn = ptr - AW'(1);
  assign rdata  = mem[ptr];

  // storage without reset so it maps onto plain RAM
  always_ff @(posedge clk) begin
    if (push && !pop)
      mem[ptr_up] <= wdata;
    else if (push && pop)
      mem[ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (push && !pop)
      ptr <= ptr_up;
    else if (pop && !push)
      ptr <= ptr_dn;
  end

  // pointer wraps through the ring one slot at a time (R9, R10)
  assert_ptr_step_R9: assert property (@(posedge clk) disable iff (rst)
    (push != pop) |=> (ptr != $past(ptr)));
  assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (push == pop) |=> $stable(ptr));

endmodule

// File: rtl/dual_stack_core.sv
module dual_stack_core
  import dsc_pkg::*;
#(
  parameter int WIDTH    = 18,
  parameter int DS_DEPTH = 8,
  parameter int RS_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic             lit_valid,
  input  logic [WIDTH-1:0] lit_data,
  output logic [WIDTH-1:0] tos,
  output logic [WIDTH-1:0] nos
);

  ctrl_t            ctrl;
  logic [WIDTH-1:0] spill_top;
  logic [WIDTH-1:0] ret_top;
  logic [WIDTH-1:0] tos_d;
  logic [WIDTH-1:0] nos_d;

  dsc_decode u_dec (
    .op_valid  (op_valid),
    .op_code   (op_code),
    .lit_valid (lit_valid),
    .ctrl      (ctrl)
  );

  dsc_lifo_ring #(.WIDTH(WIDTH), .DEPTH(DS_DEPTH)) u_spill (
    .clk   (clk),
    .rst   (rst),
    .push  (ctrl.ds_push),
    .pop   (ctrl.ds_pop),
    .wdata (nos),
    .rdata (spill_top)
  );

  dsc_lifo_ring #(.WIDTH(WIDTH), .DEPTH(RS_DEPTH)) u_ret (
    .clk   (clk),
    .rst   (rst),
    .push  (ctrl.rs_push),
    .pop   (ctrl.rs_pop),
    .wdata (tos),
    .rdata (ret_top)
  );

  always_comb begin
    unique case (ctrl.tsel)
      TS_NOS:  tos_d = nos;
      TS_LIT:  tos_d = lit_data;
      TS_RET:  tos_d = ret_top;
      TS_XOR:  tos_d = tos ^ nos;
      default: tos_d = tos;
    endcase
    unique case (ctrl.nsel)
      NS_TOS:   nos_d = tos;
      NS_SPILL: nos_d = spill_top;
      default:  nos_d = nos;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tos <= '0;
      nos <= '0;
    end else begin
      tos <= tos_d;
      nos <= nos_d;
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (tos == '0) && (nos == '0));
  assert_dup_R2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !lit_valid && op_code == 3'd1)
    |=> (tos == $past(tos)) && (nos == $past(tos)));
  assert_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !lit_valid && op_code == 3'd2) |=> (tos == $past(nos)));
  assert_over_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !lit_valid && op_code == 3'd3)
    |=> (tos == $past(nos)) && (nos == $past(tos)));
  assert_push_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !lit_valid && op_code == 3'd4) |=> (tos == $past(nos)));
  assert_xor_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !lit_valid && op_code == 3'd6)
    |=> (tos == ($past(tos) ^ $past(nos))));
  assert_literal_R7: assert property (@(posedge clk) disable iff (rst)
    lit_valid |=> (tos == $past(lit_data)) && (nos == $past(tos)));
  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!lit_valid && (!op_valid || op_code == 3'd0 || op_code == 3'd7))
    |=> $stable(tos) && $stable(nos));

endmodule

// File: tb/dual_stack_core_test.sv
module dual_stack_core_test;

  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_valid = 1'b0;
  logic [2:0]   op_code = 3'd0;
  logic         lit_valid = 1'b0;
  logic [W-1:0] lit_data = '0;
  logic [W-1:0] tos;
  logic [W-1:0] nos;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // behavioural model: index 0 is the top
  logic [W-1:0] ds[$];
  logic [W-1:0] rs[$];
  bit model_on = 1'b0;

  always #4 clk = ~clk;

  dual_stack_core uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .lit_valid(lit_valid), .lit_data(lit_data), .tos(tos), .nos(nos)
  );

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_step(input bit lv, input logic [W-1:0] ld,
                            input bit ov, input logic [2:0] oc);
    logic [W-1:0] a;
    logic [W-1:0] b;
    if (lv) ds.push_front(ld);
    else if (ov) begin
      case (oc)
        3'd1: ds.push_front(ds[0]);
        3'd2: a = ds.pop_front();
        3'd3: ds.push_front(ds[1]);
        3'd4: begin a = ds.pop_front(); rs.push_front(a); end
        3'd5: begin a = rs.pop_front(); ds.push_front(a); end
        3'd6: begin a = ds.pop_front(); b = ds.pop_front(); ds.push_front(a ^ b); end
        default: ;
      endcase
    end
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic step(input bit ov, input logic [2:0] oc, input bit lv,
                      input logic [W-1:0] ld, input string req);
    op_valid = ov; op_code = oc; lit_valid = lv; lit_data = ld;
    @(negedge clk);
    op_valid = 1'b0; lit_valid = 1'b0;
    if (model_on) begin
      model_step(lv, ld, ov, oc);
      check(req, tos, ds[0]);
      check(req, nos, ds[1]);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    ds.delete(); rs.delete();
    ds.push_front('0); ds.push_front('0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [W-1:0] va;
    logic [W-1:0] vb;
    @(negedge clk);
    do_reset();
    check("R1 tos after reset", tos, '0);
    check("R1 nos after reset", nos, '0);

    model_on = 1'b1;
    step(0, 3'd0, 1, 18'h00a5, "R7 literal");
    step(0, 3'd0, 1, 18'h1234, "R7 literal");
    step(1, 3'd1, 0, '0, "R2 dup");
    step(1, 3'd3, 0, '0, "R4 over");
    step(1, 3'd6, 0, '0, "R6 xor");
    step(1, 3'd2, 0, '0, "R3 drop");
    step(1, 3'd4, 0, '0, "R5 push");
    step(1, 3'd5, 0, '0, "R5 pop");
    step(1, 3'd2, 1, 18'h3c3c3, "R7 literal wins over drop");
    step(0, 3'd1, 0, '0, "R8 valid low");
    step(1, 3'd0, 0, '0, "R8 idle code");
    step(1, 3'd7, 0, '0, "R8 reserved code");

    // random traffic kept inside both stacks' depth
    for (int i = 0; i < 400; i++) begin
      int r;
      logic [2:0] c;
      r = $urandom_range(0, 6);
      c = 3'(r);
      if ((c == 3'd1 || c == 3'd3 || c == 3'd5 || c == 3'd0) && ds.size() >= 10) c = 3'd2;
      if ((c == 3'd2 || c == 3'd4 || c == 3'd6) && ds.size() <= 3) c = 3'd0;
      if (c == 3'd4 && rs.size() >= 8) c = 3'd6;
      if (c == 3'd5 && rs.size() == 0) c = 3'd0;
      if (c == 3'd0) step(0, 3'd0, 1, W'($urandom), "R7 random literal");
      else step(1, c, 0, '0, "R8 random primitive");
    end

    // exchange sequence with a marker on the return stack
    do_reset();
    step(0, 3'd0, 1, 18'h2bead, "R11 marker");
    step(1, 3'd4, 0, '0, "R11 marker push");
    for (int p = 0; p < 25; p++) begin
      va = W'($urandom); vb = W'($urandom);
      step(0, 3'd0, 1, va, "R11 load a");
      step(0, 3'd0, 1, vb, "R11 load b");
      step(1, 3'd3, 0, '0, "R11 over");
      step(1, 3'd4, 0, '0, "R11 push");
      step(1, 3'd3, 0, '0, "R11 over");
      step(1, 3'd6, 0, '0, "R11 xor");
      step(1, 3'd6, 0, '0, "R11 xor");
      step(1, 3'd5, 0, '0, "R11 pop");
      check("R11 swapped top", tos, va);
      check("R11 swapped next", nos, vb);
      step(1, 3'd2, 0, '0, "R11 drop");
      step(1, 3'd2, 0, '0, "R11 drop");
    end
    step(1, 3'd5, 0, '0, "R11 marker pop");
    check("R11 return stack balanced", tos, 18'h2bead);
    model_on = 1'b0;

    // data stack wrap
    do_reset();
    for (int k = 1; k <= 11; k++) step(0, 3'd0, 1, W'(100 + 3 * k), "R9 fill");
    for (int k = 0; k < 9; k++) step(1, 3'd2, 0, '0, "R9 drain");
    check("R9 deepest kept item", tos, W'(100 + 3 * 2));
    step(1, 3'd2, 0, '0, "R9 drain");
    check("R9 wrapped item", tos, W'(100 + 3 * 9));

    // return stack wrap
    do_reset();
    for (int k = 1; k <= 9; k++) begin
      step(0, 3'd0, 1, W'(500 + k), "R10 load");
      step(1, 3'd4, 0, '0, "R10 push");
    end
    for (int k = 9; k >= 2; k--) begin
      step(1, 3'd5, 0, '0, "R10 pop");
      check("R10 lifo order", tos, W'(500 + k));
    end
    step(1, 3'd5, 0, '0, "R10 pop");
    check("R10 wrapped return item", tos, W'(509));

    do_reset();
    check("R1 tos after second reset", tos, '0);
    finish_run();
  end

endmodule